// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line. A write strobe loads a character together with a five-bit frame-control word. The block then sends a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit of selectable sense, and a stop period of one, one and a half or two bit times. The line rests high between frames. An idle flag tells the host when the next character can be written.

Timing comes from an external baud tick that pulses once per sixteenth of a bit. Every bit therefore lasts 16 ticks, and the half-length extra stop period lasts 8 ticks. The control word and the character are captured when the frame is loaded, so the host may change its inputs while a frame is on the line. The sequencer has six states. ST_IDLE waits for a write. ST_START sends the start bit. ST_DATA sends the data bits. ST_PARITY sends the parity bit. ST_STOP sends the first stop bit. ST_STOP_EXT sends the extra stop period. The transitions are:

ST_IDLE to ST_START on a write strobe. ST_START to ST_DATA at the end of the bit. ST_DATA stays in ST_DATA until the last data bit ends, then goes to ST_PARITY if parity is on, and to ST_STOP otherwise. ST_PARITY to ST_STOP at the end of the bit. ST_STOP goes to ST_STOP_EXT if the long-stop field is set, and to ST_IDLE otherwise. ST_STOP_EXT goes to ST_IDLE when its period ends.

Top module: `uftx_frame_tx`

## Requirements
- R1: After reset, and between frames, `tx_line` is high and `tx_idle` is 1.
- R2: A write strobe while idle loads a frame. From the next cycle the line carries a low start bit that lasts 16 baud ticks.
- R3: Control bits [1:0] select the data length: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. The data bits go out least significant bit first, one per 16 ticks.
- R4: With control bit [2] at 0, one high stop bit of 16 ticks ends the frame.
- R5: With control bit [2] at 1 and a 5-bit length, the stop period is high for 24 ticks.
- R6: With control bit [2] at 1 and a 6-, 7- or 8-bit length, two high stop bits (32 ticks) are sent.
- R7: With control bit [3] at 1 and bit [4] at 0, a parity bit follows the data and makes the count of ones in data plus parity odd. For example, 8-bit data 0xAA sends 1.
- R8: With control bits [3] and [4] both at 1, the parity bit makes the count of ones even. For example, 8-bit data 0xAA sends 0 and 0xAB sends 1.
- R9: With control bit [3] at 0, no parity bit is sent whatever bit [4] holds, and the stop period follows the last data bit directly.
- R10: The line and the state advance only on baud ticks. The frame has the same tick count whatever the spacing between ticks.
- R11: The control word and the data are sampled at load. Changes to them during a frame do not affect that frame.
- R12: A write strobe during a frame is ignored. No second frame follows.
- R13: `tx_idle` falls in the cycle after the load and rises on the clock edge that carries the last tick of the stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe that loads a character |
| wr_data | input | DATA_W | Character to send |
| frame_ctl | input | 5 | [1:0] length, [2] long stop, [3] parity on, [4] even parity |
| tx_line | output | 1 | Serial output, high when idle |
| tx_idle | output | 1 | 1 when no frame is in progress |

## Verification
The bench builds the block with its defaults: 8-bit data width and 16 ticks per bit. This keeps the full space of control words small. All 32 control encodings are swept against five data patterns with a tick on every cycle. Each bit is checked at its mid-point, and the idle flag is checked on the exact ticks around the end of the stop period. A further pass spaces the ticks three cycles apart to show that timing counts ticks and not clocks. The last pass changes the control word and data, and writes again in the middle of a frame, to show that the frame in progress keeps its loaded format.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_STOP_EXT
    } tx_state_e;

    typedef struct packed {
        logic       par_even;
        logic       par_on;
        logic       stop_long;
        logic [1:0] wlen;
    } frame_cfg_t;

    function automatic frame_cfg_t decode_ctl(input logic [4:0] ctl);
        frame_cfg_t c;
        c.wlen      = ctl[1:0];
        c.stop_long = ctl[2];
        c.par_on    = ctl[3];
        c.par_even  = ctl[4];
        return c;
    endfunction

endpackage

// File: rtl/uftx_cfg_latch.sv
module uftx_cfg_latch
    import uftx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [4:0] ctl_in,
    output frame_cfg_t cfg_q
);

    // Reset value selects 5 data bits, one stop bit, no parity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= decode_ctl(ctl_in);
        end
    end

endmodule

// File: rtl/uftx_bit_timer.sv
module uftx_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic baud_tick,
    input  logic half,
    output logic bit_done
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last = half ? HALF_LAST : FULL_LAST;
    end

    always_comb begin
        bit_done = run && baud_tick && (cnt_q == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && baud_tick) begin
            if (cnt_q == last) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] data_in,
    input  logic [1:0]        wlen,
    input  logic              par_even,
    output logic              lsb,
    output logic              last_bit,
    output logic              par_bit
);

    localparam int MIN_W = DATA_W - 3;
    localparam int RW    = $clog2(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] sh_q;
    logic [RW-1:0]     rem_q;
    logic              par_q;

    // Keep only the bits that belong to the selected length.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (i < MIN_W + int'(wlen));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            rem_q <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh_q  <= data_in;
            rem_q <= RW'(MIN_W - 1) + RW'(wlen);
            par_q <= (^(data_in & mask)) ^ ~par_even;
        end else if (shift) begin
            sh_q  <= sh_q >> 1;
            rem_q <= rem_q - 1'b1;
        end
    end

    always_comb begin
        lsb      = sh_q[0];
        last_bit = (rem_q == '0);
        par_bit  = par_q;
    end

endmodule

// File: rtl/uftx_frame_tx.sv
module uftx_frame_tx
    import uftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [4:0]        frame_ctl,
    output logic              tx_line,
    output logic              tx_idle
);

    tx_state_e  state_q, state_d;
    frame_cfg_t cfg;
    logic       load, shift, bit_done, half, run;
    logic       data_lsb, last_bit, par_bit;

    always_comb begin
        load  = (state_q == ST_IDLE) && wr_en;
        run   = (state_q != ST_IDLE);
        shift = (state_q == ST_DATA) && bit_done;
        half  = (state_q == ST_STOP_EXT) && (cfg.wlen == 2'b00);
    end

    uftx_cfg_latch u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ctl_in (frame_ctl),
        .cfg_q  (cfg)
    );

    uftx_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (load),
        .run       (run),
        .baud_tick (baud_tick),
        .half      (half),
        .bit_done  (bit_done)
    );

    uftx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .data_in  (wr_data),
        .wlen     (wr_en && state_q == ST_IDLE ? frame_ctl[1:0] : cfg.wlen),
        .par_even (frame_ctl[4]),
        .lsb      (data_lsb),
        .last_bit (last_bit),
        .par_bit  (par_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) state_d = ST_START;
            end
            ST_START: begin
                if (bit_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_done && last_bit) begin
                    state_d = cfg.par_on ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_done) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (bit_done) state_d = cfg.stop_long ? ST_STOP_EXT : ST_IDLE;
            end
            ST_STOP_EXT: begin
                if (bit_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_line = 1'b1;
        tx_idle = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin tx_line = 1'b1; tx_idle = 1'b1; end
            ST_START:    tx_line = 1'b0;
            ST_DATA:     tx_line = data_lsb;
            ST_PARITY:   tx_line = par_bit;
            ST_STOP:     tx_line = 1'b1;
            ST_STOP_EXT: tx_line = 1'b1;
            default:     begin tx_line = 1'b1; tx_idle = 1'b1; end
        endcase
    end

endmodule

// File: rtl/uftx_chk.sv
module uftx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic wr_en,
    input logic tx_line,
    input logic tx_idle
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> tx_line);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && wr_en) |=> !tx_line);

    // R13
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && wr_en) |=> !tx_idle);

    // R13
    leave_idle_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !wr_en) |=> tx_idle);

    // R10
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_idle && !baud_tick) |=> ($stable(tx_line) && !tx_idle));

endmodule

bind uftx_frame_tx uftx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_en     (wr_en),
    .tx_line   (tx_line),
    .tx_idle   (tx_idle)
);

// File: tb/test_uftx_frame_tx.sv
module test_uftx_frame_tx;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [4:0] frame_ctl = '0;
    logic       tx_line, tx_idle;

    int n_chk = 0;
    int n_err = 0;
    int tick_div = 1;
    int div_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        baud_tick = (div_cnt == 0);
        div_cnt = (div_cnt + 1 >= tick_div) ? 0 : div_cnt + 1;
    end

    uftx_frame_tx i_uftx_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .frame_ctl (frame_ctl),
        .tx_line   (tx_line),
        .tx_idle   (tx_idle)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Send one frame and check every bit mid-point and the idle edge.
    task automatic run_frame(input logic [7:0] data, input logic [4:0] ctl,
                             input bit disturb, input string tag);
        int   n, p, nexp, total, cnt;
        logic par;
        logic exp_bits [0:12];
        string lbl [0:12];
        string end_tag;
        bit   ticked, pulse_on;
        n     = 5 + int'(ctl[1:0]);
        p     = ctl[3] ? 1 : 0;
        par   = (^(data & ((8'd1 << n) - 8'd1))) ^ ~ctl[4];
        exp_bits[0] = 1'b0; lbl[0] = "R2";
        for (int i = 0; i < n; i++) begin
            exp_bits[1+i] = data[i]; lbl[1+i] = "R3";
        end
        if (p == 1) begin
            exp_bits[1+n] = par; lbl[1+n] = ctl[4] ? "R8" : "R7";
        end
        exp_bits[1+n+p] = 1'b1; lbl[1+n+p] = (p == 0) ? "R9" : "R4";
        nexp = 2 + n + p;
        if (ctl[2] && n > 5) begin
            exp_bits[nexp] = 1'b1; lbl[nexp] = "R6"; nexp++;
        end
        total = 16 * (2 + n + p) + (ctl[2] ? ((n == 5) ? 8 : 16) : 0);
        end_tag = !ctl[2] ? "R4" : ((n == 5) ? "R5" : "R6");
        if (tag != "") begin
            for (int i = 0; i < nexp; i++) lbl[i] = tag;
            end_tag = tag;
        end
        @(negedge clk);
        wr_data = data; frame_ctl = ctl; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R13", tx_idle, 1'b0);
        cnt = 0; pulse_on = 0;
        while (cnt < total) begin
            @(posedge clk);
            ticked = baud_tick;
            @(negedge clk);
            if (pulse_on) begin
                wr_en = 1'b0; pulse_on = 0;
            end
            if (ticked) begin
                cnt++;
                if (cnt % 16 == 8 && cnt / 16 < nexp)
                    chk(lbl[cnt/16], tx_line, exp_bits[cnt/16]);
                if (cnt == total - 1) chk(end_tag, tx_idle, 1'b0);
                if (cnt == total) begin
                    chk(end_tag, tx_idle, 1'b1);
                    chk("R1", tx_line, 1'b1);
                end
                if (disturb && cnt == 20) begin
                    wr_data = ~data; frame_ctl = ~ctl; wr_en = 1'b1; pulse_on = 1;
                end
            end
        end
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++; n_chk++;
        $display("FAIL R10 watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] pats [0:4];
        pats[0] = 8'hAA; pats[1] = 8'hAB; pats[2] = 8'h00;
        pats[3] = 8'hFF; pats[4] = 8'h5C;
        repeat (4) @(negedge clk);
        chk("R1", tx_line, 1'b1);
        chk("R1", tx_idle, 1'b1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", tx_line, 1'b1);
        chk("R1", tx_idle, 1'b1);

        // Full sweep of control encodings, tick every cycle.
        for (int c = 0; c < 32; c++) begin
            for (int d = 0; d < 5; d++) begin
                run_frame(pats[d], 5'(c), 1'b0, "");
            end
        end

        // Sparse ticks: timing counts ticks, not clocks.
        tick_div = 3;
        run_frame(8'h96, 5'b01100, 1'b0, "R10");
        run_frame(8'h3B, 5'b00100, 1'b0, "R10");
        run_frame(8'hC5, 5'b11011, 1'b0, "R10");
        tick_div = 1;

        // Mid-frame changes and writes are ignored.
        run_frame(8'h5A, 5'b01011, 1'b1, "R11");
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R12", tx_idle, 1'b1);
        end
        run_frame(8'h21, 5'b10100, 1'b1, "R11");
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R12", tx_line, 1'b1);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule